// File: doc/BRIEF.md
# Configurable Logic Element Cell

This block models a single programmable logic cell of the kind tiled across a reconfigurable fabric. A 16-entry lookup table, one flip-flop, a carry stage and a cascade stage are all steered by a 22-bit configuration word. The word is presented on a parallel bus and captured with a one-cycle load strobe. The cell evaluates either an arbitrary 4-input function or, in arithmetic mode, a sum bit and a carry bit. The cascade stage can merge the table result with a neighbour's cascade signal. Each of the two routing outputs independently shows either the combinational result or the stored register value. One cell can therefore serve an unrelated logic function and an unrelated register at the same time, or present a registered and an unregistered copy of the same result.

A small sequencer has two states, `CFG_BLANK` and `CFG_LIVE`. The cell leaves reset in `CFG_BLANK`, where every output is 0 and the register stays cleared. The transition `BLANK->LIVE` fires on a load strobe. The transition `LIVE->LIVE` (reload) also fires on a strobe and replaces the word while the register keeps its value. Without a strobe, each state holds.

Configuration word layout, used by every requirement below: bits [15:0] table `tt`, bit 16 `arith`, bit 17 `acc_fb`, bit 18 `casc_en`, bit 19 `casc_or`, bit 20 `sel_a`, bit 21 `sel_b`.

Top module: `lec_cell`

## Requirements
- R1: After reset and until the first load strobe, the cell is in `CFG_BLANK`. In that state `route_a`, `route_b`, `carry_out` and `casc_out` are 0 and the register stays 0, whatever `d_in`, `ce`, `carry_in` or `casc_in` do.
- R2: A clock edge with `cfg_load` high captures `cfg_word` and moves the cell to `CFG_LIVE`. The word holds until the next strobe, and changes on `cfg_word` without a strobe have no effect. On the strobe edge the register keeps its value.
- R3: With `arith`=0, the table result is `tt[d_in]`. The index has `d_in[0]` as its least significant bit and `d_in[3]` as its most significant bit.
- R4: `route_a` shows the register when `sel_a`=1 and the combinational result when `sel_a`=0. `route_b` does the same under `sel_b`. The two selects are independent.
- R5: In `CFG_LIVE`, outside a load cycle, `sclr`=1 clears the register on the next edge regardless of `ce`. With `sclr`=0 and `ce`=1 the register captures the combinational result. With both low, the register holds.
- R6: With `arith`=1, the index is `{carry_in, b, d_in[0]}`, with `carry_in` as the MSB. The result is `tt[index]` and `carry_out` is `tt[8+index]`. With `arith`=0, `carry_out` is 0.
- R7: In arithmetic mode, `b` is the register output when `acc_fb`=1 and `d_in[1]` otherwise. This lets the cell accumulate.
- R8: With `casc_en`=1, the combinational result is the table result ANDed with `casc_in` (`casc_or`=0) or ORed with it (`casc_or`=1). With `casc_en`=0, `casc_in` is ignored. `casc_out` equals the combinational result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_word | input | 22 | Configuration word |
| d_in | input | 4 | Data inputs |
| carry_in | input | 1 | Carry from lower-order cell |
| casc_in | input | 1 | Cascade from neighbouring cell |
| ce | input | 1 | Register clock enable |
| sclr | input | 1 | Synchronous register clear |
| route_a | output | 1 | Routing output A |
| route_b | output | 1 | Routing output B |
| carry_out | output | 1 | Carry to higher-order cell |
| casc_out | output | 1 | Cascade to next cell |

## Verification
The bench targets four corner cases.
- Index bit order: table patterns that are asymmetric in `d_in`, such as indices 1 against 2 and 0 against 8, would expose a reversed index, which returns the wrong bit.
- Clear priority: asserting `sclr` and `ce` together would expose a cell that captures data instead of clearing.
- Accumulator feedback: a cell that ignored the feedback would not toggle under a constant operand.
- Cascade ignore: toggling `casc_in` with cascade disabled would expose a cell that still gated its result.

Random reloads and changes of the unloaded word catch any cell that tracks the bus live or drops its register on reload.

// File: rtl/lec_pkg.sv
`timescale 1ns/1ps
package lec_pkg;
    localparam int K       = 4;
    localparam int TT_W    = 1 << K;
    localparam int HALF_W  = TT_W / 2;
    localparam int AIDX_W  = K - 1;
    localparam int N_ROUTE = 2;

    typedef struct packed {
        logic            sel_b;
        logic            sel_a;
        logic            casc_or;
        logic            casc_en;
        logic            acc_fb;
        logic            arith;
        logic [TT_W-1:0] tt;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic {
        CFG_BLANK = 1'b0,
        CFG_LIVE  = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/lec_cfg_ctrl.sv
`timescale 1ns/1ps
module lec_cfg_ctrl
    import lec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    output cfg_t             cfg_q,
    output logic             live,
    output logic             ff_hold
);
    cfg_state_e state_q, state_d;

    // state register and configuration store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_BLANK;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_load) begin
                cfg_q <= cfg_t'(cfg_word);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_BLANK: if (cfg_load) state_d = CFG_LIVE;
            CFG_LIVE:  state_d = CFG_LIVE;
            default:   state_d = CFG_BLANK;
        endcase
    end

    // outputs
    always_comb begin
        live    = 1'b0;
        ff_hold = 1'b1;
        unique case (state_q)
            CFG_BLANK: begin
                live    = 1'b0;
                ff_hold = 1'b1;
            end
            CFG_LIVE: begin
                live    = 1'b1;
                ff_hold = cfg_load;
            end
            default: begin
                live    = 1'b0;
                ff_hold = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lec_logic.sv
`timescale 1ns/1ps
module lec_logic
    import lec_pkg::*;
(
    input  cfg_t         cfg,
    input  logic [K-1:0] d_in,
    input  logic         carry_in,
    input  logic         casc_in,
    input  logic         reg_q,
    output logic         comb,
    output logic         cout
);
    logic [HALF_W-1:0] sum_tab;
    logic [HALF_W-1:0] cry_tab;
    logic [AIDX_W-1:0] aidx;
    logic              op_b;
    logic              tab_v;

    assign sum_tab = cfg.tt[HALF_W-1:0];
    assign cry_tab = cfg.tt[TT_W-1:HALF_W];

    always_comb begin
        op_b = cfg.acc_fb ? reg_q : d_in[1];
        aidx = {carry_in, op_b, d_in[0]};
        if (cfg.arith) begin
            tab_v = sum_tab[aidx];
            cout  = cry_tab[aidx];
        end else begin
            tab_v = cfg.tt[d_in];
            cout  = 1'b0;
        end
    end

    always_comb begin
        if (!cfg.casc_en) begin
            comb = tab_v;
        end else if (cfg.casc_or) begin
            comb = tab_v | casc_in;
        end else begin
            comb = tab_v & casc_in;
        end
    end
endmodule

// File: rtl/lec_ff.sv
`timescale 1ns/1ps
module lec_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ce,
    input  logic sclr,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!hold) begin
            if (sclr) begin
                q <= 1'b0;
            end else if (ce) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/lec_cell.sv
`timescale 1ns/1ps
module lec_cell
    import lec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [K-1:0]     d_in,
    input  logic             carry_in,
    input  logic             casc_in,
    input  logic             ce,
    input  logic             sclr,
    output logic             route_a,
    output logic             route_b,
    output logic             carry_out,
    output logic             casc_out
);
    cfg_t               cfg_q;
    logic               live;
    logic               ff_hold;
    logic               ff_q;
    logic               comb;
    logic               lut_cout;
    logic               cfg_arith;
    logic [N_ROUTE-1:0] route_sel;
    logic [N_ROUTE-1:0] route_v;

    lec_cfg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .cfg_q    (cfg_q),
        .live     (live),
        .ff_hold  (ff_hold)
    );

    lec_logic u_logic (
        .cfg      (cfg_q),
        .d_in     (d_in),
        .carry_in (carry_in),
        .casc_in  (casc_in),
        .reg_q    (ff_q),
        .comb     (comb),
        .cout     (lut_cout)
    );

    lec_ff u_ff (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (ff_hold),
        .ce    (ce),
        .sclr  (sclr),
        .d     (comb),
        .q     (ff_q)
    );

    assign cfg_arith = cfg_q.arith;
    assign route_sel = {cfg_q.sel_b, cfg_q.sel_a};

    for (genvar g = 0; g < N_ROUTE; g++) begin : g_route
        assign route_v[g] = live & (route_sel[g] ? ff_q : comb);
    end

    assign route_a   = route_v[0];
    assign route_b   = route_v[1];
    assign carry_out = live & lut_cout;
    assign casc_out  = live & comb;
endmodule

// File: rtl/lec_cell_chk.sv
`timescale 1ns/1ps
module lec_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_load,
    input logic ce,
    input logic sclr,
    input logic live,
    input logic ff_q,
    input logic cfg_arith,
    input logic route_a,
    input logic route_b,
    input logic carry_out,
    input logic casc_out
);
    // R1
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (!route_a && !route_b && !carry_out && !casc_out && !ff_q));

    // R2
    load_goes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> live);

    // R2
    load_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> $stable(ff_q));

    // R5
    sclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && sclr && !cfg_load) |=> !ff_q);

    // R5
    ce_low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !sclr && !ce) |=> $stable(ff_q));

    // R6
    no_carry_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !cfg_arith) |-> !carry_out);
endmodule

bind lec_cell lec_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .ce        (ce),
    .sclr      (sclr),
    .live      (live),
    .ff_q      (ff_q),
    .cfg_arith (cfg_arith),
    .route_a   (route_a),
    .route_b   (route_b),
    .carry_out (carry_out),
    .casc_out  (casc_out)
);

// File: tb/sim_lec_cell.sv
`timescale 1ns/1ps
module sim_lec_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [21:0] cfg_word = '0;
    logic [3:0]  d_in = '0;
    logic        carry_in = 1'b0;
    logic        casc_in = 1'b0;
    logic        ce = 1'b0;
    logic        sclr = 1'b0;
    logic        route_a, route_b, carry_out, casc_out;

    int checks = 0;
    int errors = 0;

    logic [21:0] cfg_m = '0;
    logic        live_m = 1'b0;
    logic        q_m = 1'b0;

    always #5 clk = ~clk;

    lec_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .d_in(d_in), .carry_in(carry_in), .casc_in(casc_in), .ce(ce), .sclr(sclr),
        .route_a(route_a), .route_b(route_b), .carry_out(carry_out), .casc_out(casc_out)
    );

    function automatic logic [21:0] mk(input logic [15:0] tt, input logic ar, input logic fb,
                                       input logic cen, input logic cor, input logic sa, input logic sb);
        return {sb, sa, cor, cen, fb, ar, tt};
    endfunction

    // returns {carry, comb}
    function automatic logic [1:0] model(input logic [21:0] c, input logic [3:0] d,
                                         input logic ci, input logic cs, input logic q);
        logic b, tv, co, cb;
        logic [2:0] ix;
        b  = c[17] ? q : d[1];
        ix = {ci, b, d[0]};
        if (c[16]) begin
            tv = c[ix];
            co = c[8 + ix];
        end else begin
            tv = c[d];
            co = 1'b0;
        end
        if (!c[18])     cb = tv;
        else if (c[19]) cb = tv | cs;
        else            cb = tv & cs;
        return {co, cb};
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic ld, input logic [21:0] w, input logic [3:0] d,
                        input logic ci, input logic cs, input logic ce_i, input logic sc);
        logic [1:0] r;
        logic ea, eb, ec, ex;
        @(negedge clk);
        cfg_load = ld; cfg_word = w; d_in = d; carry_in = ci; casc_in = cs; ce = ce_i; sclr = sc;
        #1;
        r = model(cfg_m, d, ci, cs, q_m);
        if (live_m) begin
            ea = cfg_m[20] ? q_m : r[0];
            eb = cfg_m[21] ? q_m : r[0];
            ec = r[1];
            ex = r[0];
        end else begin
            ea = 1'b0; eb = 1'b0; ec = 1'b0; ex = 1'b0;
        end
        chk(tag, "route_a", route_a, ea);
        chk(tag, "route_b", route_b, eb);
        chk(tag, "carry_out", carry_out, ec);
        chk(tag, "casc_out", casc_out, ex);
        if (ld) begin
            cfg_m  = w;
            live_m = 1'b1;
        end else if (live_m) begin
            if (sc)        q_m = 1'b0;
            else if (ce_i) q_m = r[0];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [21:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: blank state ignores activity
        step("R1", 0, 22'h3FFFFF, 4'hF, 1, 1, 1, 0);
        step("R1", 0, 22'h3FFFFF, 4'h0, 1, 1, 1, 0);
        step("R1", 0, 22'h155555, 4'h5, 0, 1, 1, 0);
        // R2: load normal-mode function, A comb, B register
        w = mk(16'h8002, 0, 0, 0, 0, 0, 1);
        step("R2", 1, w, 4'h1, 0, 0, 1, 0);
        // R3: index order
        step("R3", 0, 22'h3FFFFF, 4'h1, 0, 0, 0, 0);
        step("R3", 0, 22'h000000, 4'h2, 0, 0, 0, 0);
        step("R3", 0, 22'h000000, 4'hF, 0, 0, 0, 0);
        step("R3", 0, 22'h000000, 4'h8, 0, 0, 0, 0);
        step("R3", 0, 22'h000000, 4'h0, 0, 0, 0, 0);
        // R5: capture, clear priority, hold
        step("R5", 0, 22'h0, 4'h1, 0, 0, 1, 0);
        step("R5", 0, 22'h0, 4'h2, 0, 0, 0, 0);
        step("R5", 0, 22'h0, 4'h1, 0, 0, 1, 1);
        step("R5", 0, 22'h0, 4'h1, 0, 0, 0, 0);
        step("R5", 0, 22'h0, 4'h1, 0, 0, 1, 0);
        // R2: reload keeps register, swap selects
        w = mk(16'h0000, 0, 0, 0, 0, 1, 0);
        step("R2", 1, w, 4'h1, 0, 0, 1, 1);
        step("R4", 0, 22'h0, 4'h3, 0, 0, 0, 0);
        step("R4", 0, 22'h0, 4'h3, 0, 0, 1, 0);
        step("R4", 0, 22'h0, 4'h3, 0, 0, 0, 0);
        // R6: full adder tables, all operand/carry combinations
        w = mk(16'hE896, 1, 0, 0, 0, 0, 1);
        step("R6", 1, w, 4'h0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            step("R6", 0, 22'h0, {2'b00, i[1], i[0]}, i[2], 0, 1, 0);
        end
        // R7: accumulator feedback
        w = mk(16'hE896, 1, 1, 0, 0, 1, 0);
        step("R7", 1, w, 4'h0, 0, 0, 0, 1);
        for (int i = 0; i < 6; i++) begin
            step("R7", 0, 22'h0, 4'h1, i[2], 0, 1, 0);
        end
        // R8: cascade AND, OR, disabled
        w = mk(16'hFFFF, 0, 0, 1, 0, 0, 0);
        step("R8", 1, w, 4'h0, 0, 0, 0, 0);
        step("R8", 0, 22'h0, 4'h6, 0, 0, 0, 0);
        step("R8", 0, 22'h0, 4'h6, 0, 1, 0, 0);
        w = mk(16'h0000, 0, 0, 1, 1, 0, 0);
        step("R8", 1, w, 4'h0, 0, 0, 0, 0);
        step("R8", 0, 22'h0, 4'h9, 0, 1, 0, 0);
        step("R8", 0, 22'h0, 4'h9, 0, 0, 0, 0);
        w = mk(16'h0001, 0, 0, 0, 1, 0, 0);
        step("R8", 1, w, 4'h0, 0, 0, 0, 0);
        step("R8", 0, 22'h0, 4'h0, 0, 0, 0, 0);
        step("R8", 0, 22'h0, 4'h0, 0, 1, 0, 0);
        step("R8", 0, 22'h0, 4'h4, 0, 1, 0, 0);
        // R4 R6 R8: random mix with occasional reloads
        for (int i = 0; i < 400; i++) begin
            step("R4/R6/R8", ($urandom % 10) == 0, 22'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule